// File: doc/BRIEF.md
# 66b Block Lock with Windowed Thresholds

This block finds and holds the block boundary of a received 64b/66b stream. An upstream gearbox delivers one 66-bit window per valid cycle at its current bit alignment. The block classifies the two-bit sync header of each window as good or bad and runs a two-state machine. While hunting, it declares lock once enough good headers arrive within a counting window. While locked, it drops lock once too many bad headers arrive within a second window. When the alignment is wrong, it sends a one-cycle slip request back to the gearbox.

The four thresholds are inputs, so software can set them at run time. The lock rule needs `cfg_lock_good` good headers out of `cfg_lock_win`. The loss rule fires at `cfg_loss_bad` bad headers out of `cfg_loss_win`. Setting both lock values to 64 gives the strict rule of 64 consecutive good headers. Setting the loss pair to 16 of 64 gives the usual loss rule. The windows are tumbling: both counts clear at the end of each window, and there is no sliding history.

Top module: `blk_lock_66`

## Requirements
- R1: Bits [1:0] of `win_data` hold the sync header. The values 2'b01 and 2'b10 are good. The values 2'b00 and 2'b11 are bad.
- R2: While hunting, `block_lock` rises in the cycle after the counted header that brings the good count of the current window to `cfg_lock_good`. The window is `cfg_lock_win` counted headers long, and the count restarts after lock is declared.
- R3: While hunting, a bad header that makes the bad count of the current window exceed `cfg_lock_win - cfg_lock_good` raises `slip` and restarts the window. With equal lock values, every bad header therefore slips.
- R4: `slip` is high for exactly one cycle per slip request.
- R5: After a slip, the next 2 cycles with `win_valid` high are not counted.
- R6: While locked, the counted bad header that brings the bad count of the current window to `cfg_loss_bad` does two things in the following cycle: `block_lock` falls and `slip` rises. The block then hunts again.
- R7: While locked, both counts restart after every `cfg_loss_win` counted headers, so bad headers do not carry over from one window into the next.
- R8: A cycle with `win_valid` low changes no count and no output, and it does not raise `slip`.
- R9: If any threshold is 0 or above 64, or if `cfg_lock_good > cfg_lock_win`, or if `cfg_loss_bad > cfg_loss_win`, the block is held in reset with `block_lock` and `slip` low.
- R10: The strict settings work. With 64 of 64 and 16 of 64, lock is declared on the 64th consecutive good header, and lock is lost on the 16th bad header within a 64-header window.
- R11: After a synchronous reset, `block_lock` and `slip` are low, and the block is hunting with cleared counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_lock_good | input | 7 | Good headers needed for lock (X) |
| cfg_lock_win | input | 7 | Hunting window length (Y) |
| cfg_loss_bad | input | 7 | Bad headers that drop lock (W) |
| cfg_loss_win | input | 7 | Locked window length (Z) |
| win_valid | input | 1 | A new 66-bit window is present |
| win_data | input | 66 | Received window, sync header in bits [1:0] |
| block_lock | output | 1 | Block alignment declared |
| slip | output | 1 | One-cycle request to shift alignment by one bit |

## Verification
A wrong count in this block shows up at the ports as a `block_lock` edge that arrives one header early or late. A settle counter that is off by one shifts the lock edge by one valid cycle after every slip. A missed window restart becomes visible at the next window boundary: lock drops, or fails to drop, when the bad headers of two windows are added together. The bench compares both outputs after every cycle against an arithmetic model. Any such fault is therefore reported within one window of the header that exposes it.

// File: rtl/blk_lock_pkg.sv
package blk_lock_pkg;

    localparam int LK_CFG_W    = 7;
    localparam int LK_MAX_WIN  = 64;
    localparam int LK_SETTLE_N = 2;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_LOCK = 1'b1
    } lk_state_e;

    typedef struct packed {
        logic seen;
        logic bad;
    } hdr_evt_t;

    function automatic logic hdr_is_sync(input logic [1:0] h);
        return h[1] ^ h[0];
    endfunction

endpackage

// File: rtl/blk_hdr_class.sv
module blk_hdr_class
    import blk_lock_pkg::*;
(
    input  logic       valid,
    input  logic [1:0] hdr,
    output hdr_evt_t   evt
);
    always_comb begin
        evt.seen = valid;
        evt.bad  = ~hdr_is_sync(hdr);
    end
endmodule

// File: rtl/blk_cfg_guard.sv
module blk_cfg_guard #(
    parameter int CFG_W   = 7,
    parameter int MAX_WIN = 64
) (
    input  logic [CFG_W-1:0] lock_good,
    input  logic [CFG_W-1:0] lock_win,
    input  logic [CFG_W-1:0] loss_bad,
    input  logic [CFG_W-1:0] loss_win,
    output logic             ok
);
    localparam logic [CFG_W-1:0] LIMIT = CFG_W'(MAX_WIN);

    function automatic logic in_rng(input logic [CFG_W-1:0] v);
        return (v != '0) && (v <= LIMIT);
    endfunction

    always_comb begin
        ok = in_rng(lock_good) && in_rng(lock_win) &&
             in_rng(loss_bad)  && in_rng(loss_win) &&
             (lock_good <= lock_win) && (loss_bad <= loss_win);
    end
endmodule

// File: rtl/blk_hdr_tally.sv
module blk_hdr_tally #(
    parameter int CFG_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             clr,
    input  logic             is_bad,
    output logic [CFG_W-1:0] n_hdr,
    output logic [CFG_W-1:0] n_bad
);
    logic [CFG_W-1:0] hdr_q;
    logic [CFG_W-1:0] bad_q;

    always_comb begin
        n_hdr = hdr_q + CFG_W'(1);
        n_bad = bad_q + CFG_W'(is_bad);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr_q <= '0;
            bad_q <= '0;
        end else if (en) begin
            if (clr) begin
                hdr_q <= '0;
                bad_q <= '0;
            end else begin
                hdr_q <= n_hdr;
                bad_q <= n_bad;
            end
        end
    end
endmodule

// File: rtl/blk_lock_66.sv
module blk_lock_66
    import blk_lock_pkg::*;
#(
    parameter int BLK_W    = 66,
    parameter int CFG_W    = LK_CFG_W,
    parameter int MAX_WIN  = LK_MAX_WIN,
    parameter int SETTLE_N = LK_SETTLE_N
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CFG_W-1:0] cfg_lock_good,
    input  logic [CFG_W-1:0] cfg_lock_win,
    input  logic [CFG_W-1:0] cfg_loss_bad,
    input  logic [CFG_W-1:0] cfg_loss_win,
    input  logic             win_valid,
    input  logic [BLK_W-1:0] win_data,
    output logic             block_lock,
    output logic             slip
);
    localparam int SW = $clog2(SETTLE_N + 1);

    logic             cfg_ok;
    logic             core_rst;
    hdr_evt_t         evt;
    logic             tally_en;
    logic             tally_clr;
    logic [CFG_W-1:0] n_hdr;
    logic [CFG_W-1:0] n_bad;
    logic [CFG_W-1:0] n_good;
    logic [CFG_W-1:0] slack;
    lk_state_e        st_q, st_nxt;
    logic [SW-1:0]    settle_q, settle_nxt;
    logic             slip_q, slip_nxt;
    logic             unused_payload;

    assign unused_payload = ^win_data[BLK_W-1:2];

    blk_cfg_guard #(.CFG_W(CFG_W), .MAX_WIN(MAX_WIN)) u_guard (
        .lock_good (cfg_lock_good),
        .lock_win  (cfg_lock_win),
        .loss_bad  (cfg_loss_bad),
        .loss_win  (cfg_loss_win),
        .ok        (cfg_ok)
    );

    assign core_rst = rst || !cfg_ok;

    blk_hdr_class u_class (
        .valid (win_valid),
        .hdr   (win_data[1:0]),
        .evt   (evt)
    );

    assign tally_en = evt.seen && (settle_q == '0);

    blk_hdr_tally #(.CFG_W(CFG_W)) u_tally (
        .clk    (clk),
        .rst    (core_rst),
        .en     (tally_en),
        .clr    (tally_clr),
        .is_bad (evt.bad),
        .n_hdr  (n_hdr),
        .n_bad  (n_bad)
    );

    assign n_good = n_hdr - n_bad;
    assign slack  = cfg_lock_win - cfg_lock_good;

    always_comb begin
        st_nxt     = st_q;
        slip_nxt   = 1'b0;
        tally_clr  = 1'b0;
        settle_nxt = settle_q;
        if (evt.seen) begin
            if (settle_q != '0) begin
                settle_nxt = settle_q - SW'(1);
            end else begin
                unique case (st_q)
                    ST_HUNT: begin
                        if (evt.bad && (n_bad > slack)) begin
                            slip_nxt   = 1'b1;
                            tally_clr  = 1'b1;
                            settle_nxt = SW'(SETTLE_N);
                        end else if (!evt.bad && (n_good == cfg_lock_good)) begin
                            st_nxt    = ST_LOCK;
                            tally_clr = 1'b1;
                        end else if (n_hdr == cfg_lock_win) begin
                            tally_clr = 1'b1;
                        end
                    end
                    ST_LOCK: begin
                        if (evt.bad && (n_bad == cfg_loss_bad)) begin
                            st_nxt     = ST_HUNT;
                            slip_nxt   = 1'b1;
                            tally_clr  = 1'b1;
                            settle_nxt = SW'(SETTLE_N);
                        end else if (n_hdr == cfg_loss_win) begin
                            tally_clr = 1'b1;
                        end
                    end
                    default: st_nxt = ST_HUNT;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (core_rst) begin
            st_q     <= ST_HUNT;
            slip_q   <= 1'b0;
            settle_q <= '0;
        end else begin
            st_q     <= st_nxt;
            slip_q   <= slip_nxt;
            settle_q <= settle_nxt;
        end
    end

    assign block_lock = (st_q == ST_LOCK);
    assign slip       = slip_q;

endmodule

// File: rtl/blk_lock_66_chk.sv
module blk_lock_66_chk (
    input logic       clk,
    input logic       rst,
    input logic       cfg_ok,
    input logic       win_valid,
    input logic [1:0] hdr,
    input logic       block_lock,
    input logic       slip
);
    logic hdr_good;
    assign hdr_good = (hdr == 2'b01) || (hdr == 2'b10);

    p_lock_rise_good_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(block_lock) |-> ($past(win_valid) && $past(hdr_good)));

    p_slip_from_bad_r3: assert property (@(posedge clk) disable iff (rst)
        slip |-> ($past(win_valid) && !$past(hdr_good)));

    p_slip_one_cycle_r4: assert property (@(posedge clk) disable iff (rst)
        slip |=> !slip);

    p_loss_slips_r6: assert property (@(posedge clk) disable iff (rst)
        ($fell(block_lock) && $past(cfg_ok) && !$past(rst)) |-> slip);

    p_idle_holds_r8: assert property (@(posedge clk) disable iff (rst || !cfg_ok)
        !win_valid |=> ($stable(block_lock) && !slip));

    p_bad_cfg_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !cfg_ok |=> (!block_lock && !slip));
endmodule

bind blk_lock_66 blk_lock_66_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_ok     (cfg_ok),
    .win_valid  (win_valid),
    .hdr        (win_data[1:0]),
    .block_lock (block_lock),
    .slip       (slip)
);

// File: tb/tb_blk_lock_66.sv
module tb_blk_lock_66;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  cfg_lock_good = 7'd64;
    logic [6:0]  cfg_lock_win  = 7'd64;
    logic [6:0]  cfg_loss_bad  = 7'd16;
    logic [6:0]  cfg_loss_win  = 7'd64;
    logic        win_valid = 1'b0;
    logic [65:0] win_data  = '0;
    logic        block_lock;
    logic        slip;

    int checks = 0;
    int errors = 0;

    int cx, cy, cw, cz;
    bit m_ok;
    bit m_lock, m_slip;
    int m_hdr, m_bad, m_settle;

    always #4 clk = ~clk;

    blk_lock_66 dut (
        .clk(clk), .rst(rst),
        .cfg_lock_good(cfg_lock_good), .cfg_lock_win(cfg_lock_win),
        .cfg_loss_bad(cfg_loss_bad), .cfg_loss_win(cfg_loss_win),
        .win_valid(win_valid), .win_data(win_data),
        .block_lock(block_lock), .slip(slip)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic m_clear();
        m_hdr = 0;
        m_bad = 0;
    endtask

    task automatic model_clock(input bit v, input bit b);
        m_slip = 0;
        if (!m_ok) begin
            m_lock = 0; m_settle = 0; m_clear();
            return;
        end
        if (!v) return;
        if (m_settle > 0) begin
            m_settle--;
            return;
        end
        m_hdr++;
        if (b) m_bad++;
        if (!m_lock) begin
            if (b && m_bad > (cy - cx)) begin
                m_slip = 1; m_settle = 2; m_clear();
            end else if (!b && (m_hdr - m_bad) == cx) begin
                m_lock = 1; m_clear();
            end else if (m_hdr == cy) begin
                m_clear();
            end
        end else begin
            if (b && m_bad == cw) begin
                m_lock = 0; m_slip = 1; m_settle = 2; m_clear();
            end else if (m_hdr == cz) begin
                m_clear();
            end
        end
    endtask

    task automatic apply_cfg(input int x, input int y, input int w, input int z);
        @(negedge clk);
        rst = 1'b1;
        win_valid = 1'b0;
        cfg_lock_good = 7'(x); cfg_lock_win = 7'(y);
        cfg_loss_bad  = 7'(w); cfg_loss_win = 7'(z);
        cx = x; cy = y; cw = w; cz = z;
        m_ok = (x >= 1 && x <= 64 && y >= 1 && y <= 64 && w >= 1 && w <= 64 &&
                z >= 1 && z <= 64 && x <= y && w <= z);
        m_lock = 0; m_slip = 0; m_settle = 0; m_clear();
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // One cycle: drive at negedge, sample 2 ns after the next rising edge.
    task automatic step(input bit v, input logic [1:0] h, input string tag);
        @(negedge clk);
        win_valid = v;
        win_data  = {$urandom(), $urandom(), h};
        @(posedge clk);
        model_clock(v, (h == 2'b00) || (h == 2'b11));
        #2;
        chk({tag, " lock"}, block_lock, m_lock);
        chk({tag, " slip"}, slip, m_slip);
    endtask

    function automatic logic [1:0] good_hdr();
        return ($urandom() % 2 == 0) ? 2'b01 : 2'b10;
    endfunction

    function automatic logic [1:0] bad_hdr();
        return ($urandom() % 2 == 0) ? 2'b00 : 2'b11;
    endfunction

    initial begin : watchdog
        #(8 * 190000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        // R11 reset state
        apply_cfg(64, 64, 16, 64);
        #1;
        chk("R11 reset lock", block_lock, 1'b0);
        chk("R11 reset slip", slip, 1'b0);

        // R10 strict 64 of 64 lock, 16 of 64 loss
        for (int i = 0; i < 63; i++) step(1, good_hdr(), "R10 strict hunt");
        chk("R10 no lock at 63", block_lock, 1'b0);
        step(1, good_hdr(), "R10 strict 64th");
        chk("R10 lock at 64", block_lock, 1'b1);
        // R7 window of 64 with 15 bad, then a fresh window with 15 bad
        for (int i = 0; i < 15; i++) step(1, bad_hdr(), "R7 window one bad");
        for (int i = 0; i < 49; i++) step(1, good_hdr(), "R7 window one good");
        for (int i = 0; i < 15; i++) step(1, bad_hdr(), "R7 window two bad");
        chk("R7 lock kept across windows", block_lock, 1'b1);
        step(1, bad_hdr(), "R6 16th bad");
        chk("R6 lock dropped", block_lock, 1'b0);
        chk("R6 slip raised", slip, 1'b1);
        step(0, good_hdr(), "R4 after slip");
        chk("R4 slip one cycle", slip, 1'b0);

        // R1 header classes with 1 of 1 lock and 1 of 1 loss
        apply_cfg(1, 1, 1, 1);
        step(1, 2'b01, "R1 hdr 01");
        chk("R1 01 good", block_lock, 1'b1);
        step(1, 2'b00, "R1 hdr 00");
        chk("R1 00 bad", slip, 1'b1);
        step(1, 2'b11, "R5 settle one");
        step(1, 2'b11, "R5 settle two");
        chk("R5 bad ignored in settle", slip, 1'b0);
        step(1, 2'b10, "R1 hdr 10");
        chk("R1 10 good", block_lock, 1'b1);
        // R8 idle cycles with a bad header on the data lines
        for (int i = 0; i < 6; i++) step(0, 2'b11, "R8 idle");
        chk("R8 lock held while idle", block_lock, 1'b1);
        step(1, 2'b11, "R1 hdr 11");
        chk("R1 11 bad", block_lock, 1'b0);

        // R5 settle count with 2 of 2
        apply_cfg(2, 2, 1, 4);
        step(1, bad_hdr(), "R5 first bad");
        chk("R5 slip", slip, 1'b1);
        step(1, good_hdr(), "R5 ignored a");
        step(1, good_hdr(), "R5 ignored b");
        step(1, good_hdr(), "R5 counted one");
        chk("R5 not yet locked", block_lock, 1'b0);
        step(1, good_hdr(), "R5 counted two");
        chk("R5 locked after settle", block_lock, 1'b1);

        // R2 and R3 with 3 of 5
        apply_cfg(3, 5, 2, 4);
        step(1, good_hdr(), "R2 g");
        step(1, bad_hdr(),  "R2 b");
        step(1, good_hdr(), "R2 g");
        step(1, bad_hdr(),  "R2 b");
        chk("R2 no lock at 2 good", block_lock, 1'b0);
        step(1, good_hdr(), "R2 g");
        chk("R2 lock at 3 of 5", block_lock, 1'b1);
        apply_cfg(3, 5, 2, 4);
        step(1, bad_hdr(), "R3 b1");
        step(1, bad_hdr(), "R3 b2");
        chk("R3 slack not exceeded", slip, 1'b0);
        step(1, bad_hdr(), "R3 b3");
        chk("R3 slip on third bad", slip, 1'b1);

        // R9 illegal settings hold the block quiet
        begin
            int bad_cfg [4][4] = '{'{5,4,1,1}, '{0,1,1,1}, '{1,1,3,2}, '{65,65,1,1}};
            for (int k = 0; k < 4; k++) begin
                apply_cfg(bad_cfg[k][0], bad_cfg[k][1], bad_cfg[k][2], bad_cfg[k][3]);
                for (int i = 0; i < 70; i++) step(1, good_hdr(), "R9 illegal cfg");
                chk("R9 no lock", block_lock, 1'b0);
            end
        end

        // Sweeps over several settings and error rates
        begin
            int sweep [6][4] = '{'{64,64,16,64}, '{3,5,2,4}, '{1,1,1,1},
                                '{4,4,1,8}, '{2,6,3,3}, '{10,12,4,16}};
            int rate [4] = '{0, 3, 12, 45};
            for (int k = 0; k < 6; k++) begin
                apply_cfg(sweep[k][0], sweep[k][1], sweep[k][2], sweep[k][3]);
                for (int r = 0; r < 4; r++) begin
                    for (int i = 0; i < 1200; i++) begin
                        bit v = ($urandom() % 8) != 0;
                        bit b = ($urandom() % 100) < rate[r];
                        step(v, b ? bad_hdr() : good_hdr(), "R2/R3/R5/R6/R7/R8 sweep");
                    end
                end
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule